// File: doc/BRIEF.md
# Sixteen-bit framed SPI command port

This block is the host-facing command port of a serial UART. An SPI master reaches the UART through it. Each transaction runs under an active-low chip select and carries exactly sixteen bits, most significant bit first. The first two bits are an operation code, which picks one of four actions: load the configuration, read it back, queue one byte for transmission, or take one byte from the receive queue. While the master shifts its word in, the block shifts a sixteen-bit reply out. The reply carries two status flags, then either the configuration or the oldest received byte.

No command acts during the transfer. The block latches the frame and decides at the moment chip select is released. It commits the frame only if exactly sixteen rising clock edges were seen. A frame that is cut short, or that runs too long, leaves every register and strobe untouched. The UART datapath sits outside the block and talks to it through three single-cycle strobes, a byte bus, the configuration word and three status inputs.

The SPI pins are asynchronous to the system clock. The block synchronizes and oversamples them, so the SPI clock must stay well below the system clock, with at least four system cycles in each SCLK phase.

Top module: `spi_cmd_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state: `cfg_word` becomes 0, all strobes are 0, and `spi_miso` and `spi_miso_oe` are 0.
- R2: While chip select is high (idle), `spi_miso` and `spi_miso_oe` stay 0. While a frame is active, `spi_miso_oe` is 1.
- R3: The block captures `spi_mosi` on SCLK rising edges, first bit as bit 15. Bits 15:14 are the operation code: 11 writes the configuration, 01 reads it, 10 writes transmit data, 00 reads receive data.
- R4: The reply word goes out MSB first. Bit 15 is valid before the first SCLK rising edge, and each later bit appears after an SCLK falling edge. Bit 15 is `rx_avail` and bit 14 is `tx_space`, both sampled when chip select falls.
- R5: Reply bits 13:0 depend on the operation code. For codes 11 and 01 they are the configuration word held when chip select fell. For codes 10 and 00 they are six zeros followed by `rx_data` sampled when chip select fell.
- R6: A complete write-configuration frame sets `cfg_word` to frame bits 13:0 and pulses `cfg_wr`. The field positions are: 13 FIFO enable, 12 shutdown, 11 transmit-empty interrupt mask, 10 receive interrupt mask, 9 parity interrupt mask, 8 receive-activity interrupt mask, 7 infrared mode, 6 two stop bits, 5 parity enable, 4 seven-bit words, 3:0 baud code.
- R7: A complete write-data frame that started with `tx_space` = 1 pulses `tx_wr` with `tx_byte` = frame bits 7:0. If the frame started with `tx_space` = 0, the block produces no pulse.
- R8: A complete read-data frame that started with `rx_avail` = 1 pulses `rx_rd` once. If the frame started with `rx_avail` = 0, the block produces no pulse.
- R9: A read-configuration frame produces no strobe and leaves `cfg_word` unchanged.
- R10: A frame with fewer than 16 SCLK rising edges (including zero) is aborted: no strobe, no change to `cfg_word` or `tx_byte`.
- R11: A frame with more than 16 SCLK rising edges is aborted in the same way.
- R12: Strobes are one system cycle long. At most one strobe fires per frame, and only after chip select has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sclk | input | 1 | SPI clock, idle low, asynchronous |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial reply to the master |
| spi_miso_oe | output | 1 | Output enable for the reply pin |
| rx_avail | input | 1 | Receive queue holds at least one byte |
| tx_space | input | 1 | Transmit path can take a byte |
| rx_data | input | 8 | Oldest received byte |
| cfg_word | output | 14 | Committed configuration fields |
| cfg_wr | output | 1 | One-cycle pulse when the configuration is written |
| tx_wr | output | 1 | One-cycle pulse to push `tx_byte` |
| tx_byte | output | 8 | Byte for the transmitter |
| rx_rd | output | 1 | One-cycle pulse to pop the receive queue |

## Verification
A wrong bit count or a stale opcode shows up at the strobe outputs within about three system cycles of chip-select release: a strobe is missing, extra, or of the wrong kind, or `cfg_word` holds the wrong value. A mis-timed reply index or a bad snapshot corrupts `spi_miso` at the next bit the master samples, so one reply word reveals it. An ordering error in the shift path puts configuration fields in the wrong positions, and the next read-configuration reply or `cfg_word` itself exposes it.

// File: rtl/spi_cmd_pkg.sv
// Shared definitions for the framed SPI command port.
// Assumes a two-bit operation code leads every frame.
package spi_cmd_pkg;
    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_RDATA = 2'b00,
        OP_RCFG  = 2'b01,
        OP_WDATA = 2'b10,
        OP_WCFG  = 2'b11
    } op_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings the three asynchronous SPI input pins into the clk domain through
// a SYNC_STAGES-deep flop chain, then derives single-cycle edge events.
// Assumes each SCLK phase lasts several clk cycles.
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sclk_pin,
    input  logic mosi_pin,
    output logic cs_act,
    output logic cs_fall_evt,
    output logic cs_rise_evt,
    output logic sclk_rise_evt,
    output logic sclk_fall_evt,
    output logic mosi_s
);
    localparam logic [2:0] PIN_IDLE = 3'b100;   // {cs_n, sclk, mosi}

    logic [2:0] pins_raw;
    logic [2:0] chain [SYNC_STAGES];
    logic [2:0] pins_s;
    logic [2:0] pins_last;

    assign pins_raw = {cs_n_pin, sclk_pin, mosi_pin};

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First synchronizer stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= PIN_IDLE;
                else        chain[g] <= pins_raw;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= PIN_IDLE;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign pins_s = chain[SYNC_STAGES-1];

    // Previous synchronized value, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_last <= PIN_IDLE;
        else        pins_last <= pins_s;
    end

    assign cs_act        = ~pins_s[2];
    assign cs_fall_evt   = pins_last[2] & ~pins_s[2];
    assign cs_rise_evt   = ~pins_last[2] & pins_s[2];
    assign sclk_rise_evt = ~pins_last[1] & pins_s[1];
    assign sclk_fall_evt = pins_last[1] & ~pins_s[1];
    assign mosi_s        = pins_s[0];
endmodule

// File: rtl/spi_frame_rx.sv
// Collects the incoming frame. It counts SCLK rising edges, saturating one
// past the frame length so that overlong frames stay visible. It shifts the
// operation code into its own register and keeps the trailing payload bits.
// Everything clears while chip select is inactive.
module spi_frame_rx
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_act,
    input  logic                       sclk_rise,
    input  logic                       mosi_s,
    output logic [FRAME_BITS-OP_W-1:0] payload,
    output logic [OP_W-1:0]            op_q,
    output logic [CNT_W-1:0]           bit_cnt
);
    localparam int PAY_W = FRAME_BITS - OP_W;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_OPS = CNT_W'(OP_W);

    // Bit counter: counts rising SCLK edges in the frame, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)             bit_cnt <= '0;
        else if (sclk_rise && bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end

    // Opcode register: takes the first OP_W bits of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)                 op_q <= '0;
        else if (sclk_rise && bit_cnt < CNT_OPS) op_q <= {op_q[OP_W-2:0], mosi_s};
    end

    // Payload shifter: keeps the most recent PAY_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) payload <= '0;
        else if (sclk_rise)    payload <= {payload[PAY_W-2:0], mosi_s};
    end
endmodule

// File: rtl/spi_resp_tx.sv
// Builds and serializes the reply word. It snapshots the status inputs,
// receive byte and configuration when chip select falls. The bit index
// advances on each SCLK falling edge, so bit 15 is presented before the
// first rising edge. The payload half is chosen by the second opcode bit,
// which is known before reply bit 13 goes out.
module spi_resp_tx #(
    parameter int FRAME_BITS = 16,
    parameter int CFG_W      = 14,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic              cfg_sel,
    input  logic              rx_avail,
    input  logic              tx_space,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              snap_avail,
    output logic              snap_space,
    output logic              miso,
    output logic              miso_oe
);
    localparam logic [CNT_W-1:0] IDX_END = CNT_W'(FRAME_BITS);

    logic [DATA_W-1:0]     snap_rx;
    logic [CFG_W-1:0]      snap_cfg;
    logic [CNT_W-1:0]      out_idx;
    logic [FRAME_BITS-1:0] reply;
    logic [FRAME_BITS-1:0] reply_sh;

    // Snapshot of everything the reply may carry, taken at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_avail <= 1'b0;
            snap_space <= 1'b0;
            snap_rx    <= '0;
            snap_cfg   <= '0;
        end else if (cs_fall) begin
            snap_avail <= rx_avail;
            snap_space <= tx_space;
            snap_rx    <= rx_data;
            snap_cfg   <= cfg_word;
        end
    end

    // Reply bit index: advances on SCLK falling edges, saturates past the end.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)                       out_idx <= '0;
        else if (sclk_fall && out_idx != IDX_END)    out_idx <= out_idx + 1'b1;
    end

    // Reply word and serializer.
    always_comb begin
        reply    = {snap_avail, snap_space,
                    cfg_sel ? snap_cfg : {{(CFG_W-DATA_W){1'b0}}, snap_rx}};
        reply_sh = reply << out_idx;
        miso     = cs_act & reply_sh[FRAME_BITS-1];
        miso_oe  = cs_act;
    end
endmodule

// File: rtl/spi_cmd_commit.sv
// Commits a frame when chip select rises, but only if exactly FRAME_BITS
// rising SCLK edges were counted. It holds the configuration register and
// drives the single-cycle strobes. It assumes the frame collector still
// holds the frame during the cycle that flags the chip-select rise.
module spi_cmd_commit
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CFG_W      = 14,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [OP_W-1:0]   op_q,
    input  logic [CFG_W-1:0]  payload,
    input  logic              snap_avail,
    input  logic              snap_space,
    output logic [CFG_W-1:0]  cfg_word,
    output logic              cfg_wr,
    output logic              tx_wr,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_rd
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic frame_ok;
    op_e  op;

    assign frame_ok = cs_rise && (bit_cnt == CNT_FULL);
    assign op       = op_e'(op_q);

    // Register updates and strobes, all decided at the chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word <= '0;
            cfg_wr   <= 1'b0;
            tx_wr    <= 1'b0;
            tx_byte  <= '0;
            rx_rd    <= 1'b0;
        end else begin
            cfg_wr <= 1'b0;
            tx_wr  <= 1'b0;
            rx_rd  <= 1'b0;
            if (frame_ok) begin
                case (op)
                    OP_WCFG: begin
                        cfg_word <= payload;
                        cfg_wr   <= 1'b1;
                    end
                    OP_WDATA: begin
                        if (snap_space) begin
                            tx_wr   <= 1'b1;
                            tx_byte <= payload[DATA_W-1:0];
                        end
                    end
                    OP_RDATA: rx_rd <= snap_avail;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_cmd_slave.sv
// Top of the sixteen-bit framed SPI command port. It ties together the pin
// synchronizer, frame collector, reply serializer and commit logic. It
// assumes SCLK idles low and each SCLK phase spans several clk cycles.
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_cs_n,
    input  logic                         spi_sclk,
    input  logic                         spi_mosi,
    output logic                         spi_miso,
    output logic                         spi_miso_oe,
    input  logic                         rx_avail,
    input  logic                         tx_space,
    input  logic [DATA_W-1:0]            rx_data,
    output logic [FRAME_BITS-OP_W-1:0]   cfg_word,
    output logic                         cfg_wr,
    output logic                         tx_wr,
    output logic [DATA_W-1:0]            tx_byte,
    output logic                         rx_rd
);
    localparam int CFG_W = FRAME_BITS - OP_W;
    localparam int CNT_W = $clog2(FRAME_BITS + 2);

    logic             cs_act;
    logic             cs_fall_evt;
    logic             cs_rise_evt;
    logic             sclk_rise_evt;
    logic             sclk_fall_evt;
    logic             mosi_s;
    logic [CFG_W-1:0] payload;
    logic [OP_W-1:0]  op_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             snap_avail;
    logic             snap_space;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_pin(spi_cs_n), .sclk_pin(spi_sclk), .mosi_pin(spi_mosi),
        .cs_act(cs_act), .cs_fall_evt(cs_fall_evt), .cs_rise_evt(cs_rise_evt),
        .sclk_rise_evt(sclk_rise_evt), .sclk_fall_evt(sclk_fall_evt),
        .mosi_s(mosi_s)
    );

    spi_frame_rx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .sclk_rise(sclk_rise_evt), .mosi_s(mosi_s),
        .payload(payload), .op_q(op_q), .bit_cnt(bit_cnt)
    );

    spi_resp_tx #(.FRAME_BITS(FRAME_BITS), .CFG_W(CFG_W), .DATA_W(DATA_W),
                  .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall_evt),
        .sclk_fall(sclk_fall_evt), .cfg_sel(op_q[0]),
        .rx_avail(rx_avail), .tx_space(tx_space), .rx_data(rx_data),
        .cfg_word(cfg_word), .snap_avail(snap_avail), .snap_space(snap_space),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    spi_cmd_commit #(.FRAME_BITS(FRAME_BITS), .CFG_W(CFG_W), .DATA_W(DATA_W),
                     .CNT_W(CNT_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise_evt), .bit_cnt(bit_cnt),
        .op_q(op_q), .payload(payload), .snap_avail(snap_avail),
        .snap_space(snap_space), .cfg_word(cfg_word), .cfg_wr(cfg_wr),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_rd(rx_rd)
    );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
// Property checker for the command port. It watches the frame counter,
// the snapshots and the strobe outputs, and is bound into every instance
// of the top module.
module spi_cmd_slave_chk #(
    parameter int CFG_W  = 14,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5,
    parameter int FRAME_BITS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              cs_rise,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              snap_avail,
    input logic              snap_space,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              cfg_wr,
    input logic              tx_wr,
    input logic [DATA_W-1:0] tx_byte,
    input logic              rx_rd
);
    logic any_strobe;
    assign any_strobe = cfg_wr | tx_wr | rx_rd;

    // R12: never more than one strobe at a time.
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_wr, tx_wr, rx_rd}));

    // R12: strobes last a single cycle.
    assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !any_strobe);

    // R12: no strobe while a frame is active.
    assert_strobe_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> !cs_act);

    // R10, R11: a strobe follows only a frame of exactly FRAME_BITS edges.
    assert_full_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> ($past(cs_rise) && $past(bit_cnt) == CNT_W'(FRAME_BITS)));

    // R6: configuration changes only together with its strobe.
    assert_cfg_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_word) |-> cfg_wr);

    // R7: transmit byte changes only with its strobe, and needs space.
    assert_tx_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_byte) |-> tx_wr);
    assert_tx_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> $past(snap_space));

    // R8: a pop happens only when a byte was available at frame start.
    assert_rx_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> $past(snap_avail));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(
    .CFG_W(CFG_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise_evt),
    .bit_cnt(bit_cnt), .snap_avail(snap_avail), .snap_space(snap_space),
    .cfg_word(cfg_word), .cfg_wr(cfg_wr), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .rx_rd(rx_rd)
);

// File: tb/tb_spi_cmd_slave.sv
`timescale 1ns/1ps
module tb_spi_cmd_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic        rx_avail = 1'b0;
    logic        tx_space = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [13:0] cfg_word;
    logic        cfg_wr;
    logic        tx_wr;
    logic [7:0]  tx_byte;
    logic        rx_rd;

    int checks = 0;
    int failures = 0;
    int n_cfg = 0, n_tx = 0, n_rx = 0, n_multi = 0, n_low = 0;
    logic [7:0] last_tx = '0;
    logic prev_any = 1'b0;
    logic oe_seen;

    always #2.5 clk = ~clk;

    spi_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .rx_avail(rx_avail), .tx_space(tx_space), .rx_data(rx_data),
        .cfg_word(cfg_word), .cfg_wr(cfg_wr), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .rx_rd(rx_rd)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_wr) n_cfg++;
            if (tx_wr) begin n_tx++; last_tx = tx_byte; end
            if (rx_rd) n_rx++;
            if ((cfg_wr | tx_wr | rx_rd) && prev_any) n_multi++;
            if ((cfg_wr | tx_wr | rx_rd) && !spi_cs_n) n_low++;
            prev_any = cfg_wr | tx_wr | rx_rd;
        end else begin
            prev_any = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One SPI frame of nb bits; returns the sampled reply.
    task automatic spi_frame(input logic [15:0] w, input int nb, output logic [15:0] resp);
        resp = '0;
        oe_seen = 1'b0;
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (10) @(negedge clk);
        oe_seen = spi_miso_oe;
        for (int i = 0; i < nb; i++) begin
            if (i < 16) resp[15-i] = spi_miso;
            spi_mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (8) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Vector: {frame word[16], bit count[5], rx_avail, tx_space, rx_data[8]}
    localparam int NV = 15;
    localparam logic [30:0] VECS [NV] = '{
        {16'hFFFF, 5'd16, 1'b1, 1'b1, 8'h3C},  // write cfg, all ones
        {16'h4000, 5'd16, 1'b0, 1'b1, 8'h00},  // read cfg
        {16'hDA5B, 5'd16, 1'b0, 1'b0, 8'h77},  // write cfg 1A5B
        {16'h80C3, 5'd16, 1'b0, 1'b1, 8'h5A},  // write data, space
        {16'h807E, 5'd16, 1'b1, 1'b0, 8'h11},  // write data, no space
        {16'h0000, 5'd16, 1'b1, 1'b1, 8'h96},  // read data, available
        {16'h0000, 5'd16, 1'b0, 1'b1, 8'h96},  // read data, empty
        {16'hC3FF, 5'd15, 1'b1, 1'b1, 8'h01},  // short write cfg
        {16'h80AA, 5'd8,  1'b1, 1'b1, 8'h02},  // short write data
        {16'h0000, 5'd0,  1'b1, 1'b1, 8'h03},  // empty frame
        {16'hFFFF, 5'd17, 1'b1, 1'b1, 8'h04},  // long write cfg
        {16'h0000, 5'd17, 1'b1, 1'b1, 8'h05},  // long read data
        {16'h4000, 5'd16, 1'b1, 1'b0, 8'hEE},  // read cfg
        {16'h80A5, 5'd16, 1'b1, 1'b1, 8'hC8},  // write data A5
        {16'hC000, 5'd16, 1'b0, 1'b1, 8'h00}   // write cfg zero
    };

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
        summary();
    end

    initial begin
        logic [13:0] cfg_m;
        int tx_m, rx_m, cfg_n;
        logic [7:0] tx_last_m;
        logic [15:0] resp;

        cfg_m = '0; tx_m = 0; rx_m = 0; cfg_n = 0; tx_last_m = '0;
        repeat (5) @(negedge clk);
        // R1: reset state.
        chk("R1 cfg_word", 32'(cfg_word), 32'h0);
        chk("R1 strobes", 32'({cfg_wr, tx_wr, rx_rd}), 32'h0);
        chk("R1 miso", 32'({spi_miso, spi_miso_oe}), 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R2: idle pins.
        chk("R2 idle miso", 32'({spi_miso, spi_miso_oe}), 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] w;
            int nb;
            logic [15:0] exp_r, mask;
            logic full;
            string ab;
            w = VECS[v][30:15];
            nb = int'(VECS[v][14:10]);
            rx_avail = VECS[v][9];
            tx_space = VECS[v][8];
            rx_data = VECS[v][7:0];
            full = (nb == 16);
            ab = (nb < 16) ? "R10" : (nb > 16) ? "R11" : "";
            exp_r = {VECS[v][9], VECS[v][8], w[14] ? cfg_m : {6'b0, VECS[v][7:0]}};
            mask = (nb >= 16) ? 16'hFFFF : ~(16'hFFFF >> nb);
            spi_frame(w, nb, resp);
            if (full && w[15:14] == 2'b11) begin cfg_m = w[13:0]; cfg_n++; end
            if (full && w[15:14] == 2'b10 && VECS[v][8]) begin tx_m++; tx_last_m = w[7:0]; end
            if (full && w[15:14] == 2'b00 && VECS[v][9]) rx_m++;
            chk($sformatf("R4 R5 reply v%0d", v), 32'(resp & mask), 32'(exp_r & mask));
            chk($sformatf("R3 R6 R9 %s cfg v%0d", ab, v), 32'(cfg_word), 32'(cfg_m));
            chk($sformatf("R6 %s cfg_wr count v%0d", ab, v), n_cfg, cfg_n);
            chk($sformatf("R7 %s tx count v%0d", ab, v), n_tx, tx_m);
            chk($sformatf("R7 %s tx byte v%0d", ab, v), 32'(last_tx), 32'(tx_last_m));
            chk($sformatf("R8 %s rx count v%0d", ab, v), n_rx, rx_m);
            chk($sformatf("R2 idle after v%0d", v), 32'({spi_miso, spi_miso_oe}), 32'h0);
        end

        // R2: output enabled during a frame.
        spi_frame(16'h4000, 16, resp);
        chk("R2 oe in frame", 32'(oe_seen), 32'h1);
        // R12: single-cycle strobes, only after chip select rose.
        chk("R12 strobe width", n_multi, 0);
        chk("R12 strobe while low", n_low, 0);

        // R1: reset clears a written configuration.
        spi_frame(16'hFFFF, 16, resp);
        chk("R6 cfg before reset", 32'(cfg_word), 32'h3FFF);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 cfg after reset", 32'(cfg_word), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule